// File: doc/BRIEF.md
# Interrupt Redirection Service Engine

This block sits between the interrupt input pins of a 24-pin interrupt controller and the fabric that carries interrupt messages to processors. It keeps one pending bit per pin and one 64-bit redirection entry per pin. Each entry selects the vector, the delivery mode, the destination and its mode, whether the pin is edge- or level-sensitive, and whether it is masked. Pin activity arrives as numbered request events carrying a level. The engine applies edge or level rules, then services eligible pins one at a time by emitting a delivery message over a valid/ready handshake.

Level-sensitive pins are throttled by a remote-IRR bit that the engine sets in the entry when it delivers. A pin blocked this way is not serviced again until an end-of-interrupt broadcast names that entry's vector. Entries are written 32 bits at a time through a simple write port and can be read back whole through a read port. A delivery mode meaning external interrupt makes the engine fetch the vector from a legacy interrupt controller through a request/acknowledge port before it offers the message.

Top module: `irq_redir_engine`

## Requirements
- R1: After reset nothing is pending, `dlv_valid` and `leg_req` are low, and every entry reads 64'h0000_0000_0001_0000 (only the mask bit set).
- R2: Entry layout: vector 7:0, delivery mode 10:8, destination mode 11, remote-IRR 14, trigger 15 (1 = level), mask 16, destination 63:56. A write with `wr_hi`=1 replaces bits 63:32. A write with `wr_hi`=0 replaces bits 31:0 except bit 14, which keeps its value.
- R3: Request number 0 acts on pin 2. Numbers 1..23 act on the pin of the same number. Numbers of 24 and above have no effect.
- R4: On an edge pin, a request with level 1 sets the pending bit only if the entry is unmasked. A request on a masked edge pin is dropped, so unmasking the pin later delivers nothing. A request with level 0 has no effect. An edge pin's pending bit clears when its message is accepted.
- R5: On a level pin, a request with level 1 sets the pending bit even while masked, and level 0 clears it. When its message is accepted, the pin stays pending and bit 14 of its entry is set. A pin whose bit 14 is set is not delivered again.
- R6: An end-of-interrupt broadcast clears bit 14 in every entry that has it set and whose vector equals the broadcast vector. If such a pin is still pending and unmasked, it is delivered again. A broadcast with a non-matching vector changes nothing.
- R7: A pin is eligible when it is pending, unmasked, and not a level pin with bit 14 set. The lowest-numbered eligible pin is serviced first, and each service produces exactly one message.
- R8: A message carries the entry's destination, destination mode, delivery mode, vector and trigger bit.
- R9: While `dlv_valid` is high and `dlv_ready` is low, the message stays valid and unchanged. No delivery is lost or repeated.
- R10: For delivery mode 3'b111, `leg_req` stays high until `leg_ack`. The message then carries `leg_vector` instead of the entry vector. No message is offered while `leg_req` is high.
- R11: A write to an entry re-evaluates eligibility. Unmasking a pending level pin delivers it.
- R12: With the engine idle, `dlv_valid` rises on the second clock edge after the edge that captures an enabling request or write. After an acceptance, the next pick happens on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Pin request event strobe |
| evt_num | input | REQ_W | Request number |
| evt_level | input | 1 | Level carried by the request |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_hi | input | 1 | 1 writes bits 63:32, 0 writes bits 31:0 |
| wr_data | input | 32 | Write data |
| rd_idx | input | IDX_W | Entry index to read |
| rd_entry | output | 64 | Entry contents at `rd_idx` (0 when out of range) |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Broadcast vector |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Delivery message accepted |
| dlv_dest | output | 8 | Destination |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Vector |
| dlv_level | output | 1 | Trigger mode (1 = level) |
| leg_req | output | 1 | Legacy vector request |
| leg_ack | input | 1 | Legacy vector response strobe |
| leg_vector | input | 8 | Legacy vector |

## Verification
A request or entry write takes effect on the edge that captures it. On the next edge the idle engine picks a pin, so the message is visible after the second edge. Remote-IRR changes appear on the read port right after the accepting or broadcast edge. The bench drives inputs just after the rising edge. It advances a behavioural model on each rising edge from the same inputs, and compares valid, message fields, `leg_req` and the read port at the falling edge. Directed checks count the accepted messages a few cycles after each stimulus, and sample the first-cycle latency at the falling edges after the capture edge.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    localparam int ENT_W     = 64;
    localparam int VEC_LO    = 0;
    localparam int MODE_LO   = 8;
    localparam int DMODE_BIT = 11;
    localparam int RIRR_BIT  = 14;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LO   = 56;

    localparam logic [2:0]       MODE_EXT  = 3'b111;
    localparam logic [ENT_W-1:0] ENT_RESET = 64'h0000_0000_0001_0000;

    typedef struct packed {
        logic [7:0] dest;
        logic       dest_mode;
        logic [2:0] mode;
        logic [7:0] vector;
        logic       level;
    } dlv_msg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEGACY,
        ST_OFFER
    } eng_state_t;

    // Build a delivery message from a redirection entry
    function automatic dlv_msg_t entry_to_msg(input logic [ENT_W-1:0] e);
        dlv_msg_t m;
        m.dest      = e[DEST_LO +: 8];
        m.dest_mode = e[DMODE_BIT];
        m.mode      = e[MODE_LO +: 3];
        m.vector    = e[VEC_LO +: 8];
        m.level     = e[TRIG_BIT];
        return m;
    endfunction

endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_hi,
    input  logic [31:0]         wr_data,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    input  logic                rirr_set,
    input  logic [IDX_W-1:0]    rirr_idx,
    input  logic [IDX_W-1:0]    sel_idx,
    output logic [ENT_W-1:0]    sel_entry,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [ENT_W-1:0]    rd_entry,
    output logic [NUM_PINS-1:0] mask_vec,
    output logic [NUM_PINS-1:0] level_vec,
    output logic [NUM_PINS-1:0] rirr_vec
);

    logic [ENT_W-1:0] tbl [NUM_PINS];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl[g] <= ENT_RESET;
            end else begin
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    if (wr_hi) begin
                        tbl[g][63:32] <= wr_data;
                    end else begin
                        // remote-IRR is owned by the engine, not by writes
                        tbl[g][31:0] <= {wr_data[31:RIRR_BIT+1], tbl[g][RIRR_BIT],
                                         wr_data[RIRR_BIT-1:0]};
                    end
                end
                if (eoi_valid && tbl[g][RIRR_BIT] && tbl[g][VEC_LO +: 8] == eoi_vector) begin
                    tbl[g][RIRR_BIT] <= 1'b0;
                end
                if (rirr_set && rirr_idx == IDX_W'(g)) begin
                    tbl[g][RIRR_BIT] <= 1'b1;
                end
            end
        end

        assign mask_vec[g]  = tbl[g][MASK_BIT];
        assign level_vec[g] = tbl[g][TRIG_BIT];
        assign rirr_vec[g]  = tbl[g][RIRR_BIT];
    end

    assign sel_entry = (int'(sel_idx) < NUM_PINS) ? tbl[sel_idx] : '0;
    assign rd_entry  = (int'(rd_idx)  < NUM_PINS) ? tbl[rd_idx]  : '0;

endmodule

// File: rtl/irq_redir_pending.sv
module irq_redir_pending #(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5,
    parameter int REQ_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_valid,
    input  logic [REQ_W-1:0]    evt_num,
    input  logic                evt_level,
    input  logic [NUM_PINS-1:0] mask_vec,
    input  logic [NUM_PINS-1:0] level_vec,
    input  logic [NUM_PINS-1:0] rirr_vec,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [NUM_PINS-1:0] elig
);

    localparam int REDIRECT_PIN = 2;

    logic [NUM_PINS-1:0] irr_q, irr_d;
    logic                evt_hit;
    logic [IDX_W-1:0]    evt_pin;

    always_comb begin
        evt_hit = evt_valid && (int'(evt_num) < NUM_PINS);
        evt_pin = (evt_num == '0) ? IDX_W'(REDIRECT_PIN) : IDX_W'(evt_num);
        irr_d   = irr_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (clr_en && clr_idx == IDX_W'(i)) begin
                irr_d[i] = 1'b0;
            end
            // a request on the same cycle wins over the acceptance clear
            if (evt_hit && evt_pin == IDX_W'(i)) begin
                if (level_vec[i]) begin
                    irr_d[i] = evt_level;
                end else if (evt_level && !mask_vec[i]) begin
                    irr_d[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q <= '0;
        end else begin
            irr_q <= irr_d;
        end
    end

    assign elig = irr_q & ~mask_vec & ~(level_vec & rirr_vec);

endmodule

// File: rtl/irq_redir_sched.sv
module irq_redir_sched
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] elig,
    output logic [IDX_W-1:0]    pick_idx,
    input  logic [ENT_W-1:0]    pick_entry,
    output logic                dlv_valid,
    input  logic                dlv_ready,
    output dlv_msg_t            dlv_msg,
    output logic                leg_req,
    input  logic                leg_ack,
    input  logic [7:0]          leg_vector,
    output logic                done_en,
    output logic [IDX_W-1:0]    done_idx,
    output logic                done_level
);

    eng_state_t       st_q;
    dlv_msg_t         msg_q;
    logic [IDX_W-1:0] pin_q;
    logic             any_elig;

    // lowest-numbered eligible pin
    always_comb begin
        any_elig = 1'b0;
        pick_idx = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any_elig = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            msg_q <= '0;
            pin_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (any_elig) begin
                        msg_q <= entry_to_msg(pick_entry);
                        pin_q <= pick_idx;
                        st_q  <= (pick_entry[MODE_LO +: 3] == MODE_EXT) ? ST_LEGACY : ST_OFFER;
                    end
                end
                ST_LEGACY: begin
                    if (leg_ack) begin
                        msg_q.vector <= leg_vector;
                        st_q         <= ST_OFFER;
                    end
                end
                ST_OFFER: begin
                    if (dlv_ready) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign dlv_valid  = (st_q == ST_OFFER);
    assign leg_req    = (st_q == ST_LEGACY);
    assign dlv_msg    = msg_q;
    assign done_en    = dlv_valid && dlv_ready;
    assign done_idx   = pin_q;
    assign done_level = msg_q.level;

endmodule

// File: rtl/irq_redir_engine.sv
module irq_redir_engine
    import irq_redir_pkg::*;
#(
    parameter  int NUM_PINS = 24,
    parameter  int REQ_W    = 8,
    localparam int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic [REQ_W-1:0] evt_num,
    input  logic             evt_level,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_entry,
    input  logic             eoi_valid,
    input  logic [7:0]       eoi_vector,
    output logic             dlv_valid,
    input  logic             dlv_ready,
    output logic [7:0]       dlv_dest,
    output logic             dlv_dest_mode,
    output logic [2:0]       dlv_mode,
    output logic [7:0]       dlv_vector,
    output logic             dlv_level,
    output logic             leg_req,
    input  logic             leg_ack,
    input  logic [7:0]       leg_vector
);

    logic [NUM_PINS-1:0] mask_vec, level_vec, rirr_vec, elig;
    logic [IDX_W-1:0]    pick_idx, done_idx;
    logic [ENT_W-1:0]    pick_entry;
    logic                done_en, done_level;
    dlv_msg_t            msg;

    irq_redir_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .rirr_set   (done_en && done_level),
        .rirr_idx   (done_idx),
        .sel_idx    (pick_idx),
        .sel_entry  (pick_entry),
        .rd_idx     (rd_idx),
        .rd_entry   (rd_entry),
        .mask_vec   (mask_vec),
        .level_vec  (level_vec),
        .rirr_vec   (rirr_vec)
    );

    irq_redir_pending #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .REQ_W(REQ_W)) u_pending (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_num   (evt_num),
        .evt_level (evt_level),
        .mask_vec  (mask_vec),
        .level_vec (level_vec),
        .rirr_vec  (rirr_vec),
        .clr_en    (done_en && !done_level),
        .clr_idx   (done_idx),
        .elig      (elig)
    );

    irq_redir_sched #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .elig       (elig),
        .pick_idx   (pick_idx),
        .pick_entry (pick_entry),
        .dlv_valid  (dlv_valid),
        .dlv_ready  (dlv_ready),
        .dlv_msg    (msg),
        .leg_req    (leg_req),
        .leg_ack    (leg_ack),
        .leg_vector (leg_vector),
        .done_en    (done_en),
        .done_idx   (done_idx),
        .done_level (done_level)
    );

    assign dlv_dest      = msg.dest;
    assign dlv_dest_mode = msg.dest_mode;
    assign dlv_mode      = msg.mode;
    assign dlv_vector    = msg.vector;
    assign dlv_level     = msg.level;

endmodule

// File: rtl/irq_redir_engine_chk.sv
module irq_redir_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       dlv_valid,
    input logic       dlv_ready,
    input logic [7:0] dlv_dest,
    input logic       dlv_dest_mode,
    input logic [2:0] dlv_mode,
    input logic [7:0] dlv_vector,
    input logic       dlv_level,
    input logic       leg_req,
    input logic       leg_ack,
    input logic [7:0] leg_vector
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!dlv_valid && !leg_req));

    // R9
    dlv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !dlv_ready) |=> (dlv_valid &&
            $stable({dlv_dest, dlv_dest_mode, dlv_mode, dlv_vector, dlv_level})));

    // R7
    one_msg_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && dlv_ready) |=> !dlv_valid);

    // R10
    leg_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (leg_req && !leg_ack) |=> leg_req);

    // R10
    leg_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (leg_req && leg_ack) |=> (dlv_valid && !leg_req &&
            dlv_vector == $past(leg_vector) && dlv_mode == 3'b111));

    // R10
    leg_excl_chk: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> !leg_req);

endmodule

bind irq_redir_engine irq_redir_engine_chk u_chk (.*);

// File: tb/irq_redir_engine_bench.sv
`timescale 1ns/1ps
module irq_redir_engine_bench;

    localparam int N     = 24;
    localparam int IDX_W = 5;
    localparam int REQ_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             evt_valid = 1'b0;
    logic [REQ_W-1:0] evt_num = '0;
    logic             evt_level = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic             wr_hi = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [63:0]      rd_entry;
    logic             eoi_valid = 1'b0;
    logic [7:0]       eoi_vector = '0;
    logic             dlv_valid;
    logic             dlv_ready = 1'b1;
    logic [7:0]       dlv_dest;
    logic             dlv_dest_mode;
    logic [2:0]       dlv_mode;
    logic [7:0]       dlv_vector;
    logic             dlv_level;
    logic             leg_req;
    logic             leg_ack = 1'b0;
    logic [7:0]       leg_vector = '0;

    always #2 clk = ~clk;

    irq_redir_engine u_irq_redir_engine (
        .clk(clk), .rst(rst),
        .evt_valid(evt_valid), .evt_num(evt_num), .evt_level(evt_level),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_entry(rd_entry),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_dest(dlv_dest),
        .dlv_dest_mode(dlv_dest_mode), .dlv_mode(dlv_mode), .dlv_vector(dlv_vector),
        .dlv_level(dlv_level),
        .leg_req(leg_req), .leg_ack(leg_ack), .leg_vector(leg_vector)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int n_acc  = 0;
    logic [7:0] acc_q [$];

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_tbl [N];
    logic [63:0] nt [N];
    logic [N-1:0] m_irr, ni;
    int          m_busy = 0;   // 0 idle, 1 legacy wait, 2 offering
    int          m_pin  = 0;
    logic [7:0]  m_dest, m_vec;
    logic        m_dm, m_lvl;
    logic [2:0]  m_mode;

    initial begin
        for (int p = 0; p < N; p++) m_tbl[p] = 64'h1_0000;
        m_irr = '0;
    end

    always @(posedge clk) begin : ref_model
        int   pick;
        int   pin;
        logic acc;
        logic [63:0] e;
        if (rst) begin
            for (int p = 0; p < N; p++) m_tbl[p] = 64'h1_0000;
            m_irr  = '0;
            m_busy = 0;
        end else begin
            acc  = (m_busy == 2) && dlv_ready;
            pick = -1;
            if (m_busy == 0) begin
                for (int p = N - 1; p >= 0; p--) begin
                    e = m_tbl[p];
                    if (m_irr[p] && !e[16] && !(e[15] && e[14])) pick = p;
                end
            end
            for (int p = 0; p < N; p++) nt[p] = m_tbl[p];
            if (wr_en && int'(wr_idx) < N) begin
                if (wr_hi) nt[wr_idx][63:32] = wr_data;
                else nt[wr_idx][31:0] = {wr_data[31:15], m_tbl[wr_idx][14], wr_data[13:0]};
            end
            if (eoi_valid) begin
                for (int p = 0; p < N; p++)
                    if (m_tbl[p][14] && m_tbl[p][7:0] == eoi_vector) nt[p][14] = 1'b0;
            end
            if (acc && m_lvl) nt[m_pin][14] = 1'b1;
            ni = m_irr;
            if (acc && !m_lvl) ni[m_pin] = 1'b0;
            if (evt_valid) begin
                pin = (evt_num == 0) ? 2 : int'(evt_num);
                if (pin < N) begin
                    e = m_tbl[pin];
                    if (e[15]) ni[pin] = evt_level;
                    else if (evt_level && !e[16]) ni[pin] = 1'b1;
                end
            end
            case (m_busy)
                0: if (pick >= 0) begin
                    e      = m_tbl[pick];
                    m_pin  = pick;
                    m_dest = e[63:56];
                    m_dm   = e[11];
                    m_mode = e[10:8];
                    m_vec  = e[7:0];
                    m_lvl  = e[15];
                    m_busy = (e[10:8] == 3'b111) ? 1 : 2;
                end
                1: if (leg_ack) begin
                    m_vec  = leg_vector;
                    m_busy = 2;
                end
                default: if (acc) m_busy = 0;
            endcase
            for (int p = 0; p < N; p++) m_tbl[p] = nt[p];
            m_irr = ni;
        end
    end

    // per-cycle comparison and acceptance log, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R12 dlv_valid timing", {63'b0, dlv_valid}, {63'b0, m_busy == 2});
            chk("R10 leg_req", {63'b0, leg_req}, {63'b0, m_busy == 1});
            if (m_busy == 2 && dlv_valid)
                chk("R8 message fields",
                    {43'b0, dlv_dest, dlv_dest_mode, dlv_mode, dlv_vector, dlv_level},
                    {43'b0, m_dest, m_dm, m_mode, m_vec, m_lvl});
            chk("R2 read port", rd_entry, (int'(rd_idx) < N) ? m_tbl[rd_idx] : 64'h0);
            if (dlv_valid && dlv_ready) begin
                n_acc++;
                acc_q.push_back(dlv_vector);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        repeat (8) tick();
    endtask

    task automatic wr(input int idx, input logic hi, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_hi = hi; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic evt(input int num, input logic lvl);
        evt_valid = 1'b1; evt_num = REQ_W'(num); evt_level = lvl;
        tick();
        evt_valid = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        tick();
        eoi_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk_lo(input logic [7:0] vec, input logic [2:0] mode,
                                          input logic dm, input logic lvl, input logic msk);
        return {15'b0, msk, lvl, 1'b0, 2'b0, dm, mode, vec};
    endfunction

    task automatic look(input int idx);
        rd_idx = IDX_W'(idx);
        @(negedge clk);
        #0;
    endtask

    int mark;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        look(0);
        chk("R1 dlv_valid after reset", {63'b0, dlv_valid}, 64'h0);
        chk("R1 leg_req after reset", {63'b0, leg_req}, 64'h0);
        chk("R1 entry 0 after reset", rd_entry, 64'h1_0000);
        tick();
        look(23);
        chk("R1 entry 23 after reset", rd_entry, 64'h1_0000);
        tick();

        // R4/R8/R12 unmasked edge pin
        wr(4, 1'b0, mk_lo(8'h41, 3'd0, 1'b1, 1'b0, 1'b0));
        wr(4, 1'b1, 32'h1200_0000);
        mark = n_acc;
        evt(4, 1'b1);
        @(negedge clk);
        chk("R12 not valid one edge after capture", {63'b0, dlv_valid}, 64'h0);
        @(negedge clk);
        chk("R12 valid two edges after capture", {63'b0, dlv_valid}, 64'h1);
        chk("R8 destination", {56'b0, dlv_dest}, 64'h12);
        chk("R8 destination mode", {63'b0, dlv_dest_mode}, 64'h1);
        tick();
        settle();
        chk("R4 edge pin delivered once", n_acc - mark, 1);
        chk("R4 edge vector", {56'b0, acc_q[acc_q.size()-1]}, 64'h41);

        // R4 masked edge request dropped; level 0 ignored
        wr(6, 1'b1, 32'h0300_0000);
        wr(6, 1'b0, mk_lo(8'h61, 3'd0, 1'b0, 1'b0, 1'b1));
        mark = n_acc;
        evt(6, 1'b1);
        settle();
        wr(6, 1'b0, mk_lo(8'h61, 3'd0, 1'b0, 1'b0, 1'b0));
        settle();
        chk("R4 masked edge request dropped", n_acc - mark, 0);
        evt(6, 1'b0);
        settle();
        chk("R4 low level on edge pin ignored", n_acc - mark, 0);

        // R3 request number mapping
        wr(2, 1'b0, mk_lo(8'h22, 3'd0, 1'b0, 1'b0, 1'b0));
        mark = n_acc;
        evt(0, 1'b1);
        settle();
        chk("R3 request 0 goes to pin 2", n_acc - mark, 1);
        chk("R3 request 0 vector", {56'b0, acc_q[acc_q.size()-1]}, 64'h22);
        evt(30, 1'b1);
        evt(24, 1'b1);
        settle();
        chk("R3 out-of-range requests ignored", n_acc - mark, 1);

        // R5/R6/R2 level pin with remote-IRR
        wr(9, 1'b0, mk_lo(8'h90, 3'd0, 1'b0, 1'b1, 1'b0));
        mark = n_acc;
        evt(9, 1'b1);
        settle();
        chk("R5 level pin delivered", n_acc - mark, 1);
        look(9);
        chk("R5 remote-IRR set after delivery", {63'b0, rd_entry[14]}, 64'h1);
        tick();
        settle();
        chk("R5 blocked while remote-IRR set", n_acc - mark, 1);
        eoi(8'h91);
        settle();
        chk("R6 non-matching broadcast no effect", n_acc - mark, 1);
        wr(9, 1'b0, mk_lo(8'h90, 3'd0, 1'b1, 1'b1, 1'b0));
        look(9);
        chk("R2 low write keeps bit 14", {32'b0, rd_entry[31:0]},
            {32'b0, mk_lo(8'h90, 3'd0, 1'b1, 1'b1, 1'b0) | 32'h4000});
        tick();
        wr(9, 1'b1, 32'hAB00_0000);
        look(9);
        chk("R2 high write", {32'b0, rd_entry[63:32]}, 64'hAB00_0000);
        tick();
        eoi(8'h90);
        settle();
        chk("R6 matching broadcast redelivers", n_acc - mark, 2);
        evt(9, 1'b0);
        eoi(8'h90);
        settle();
        chk("R5 low level cleared pending", n_acc - mark, 2);
        look(9);
        chk("R6 broadcast clears remote-IRR", {63'b0, rd_entry[14]}, 64'h0);
        tick();

        // R10/R7 legacy vector fetch and priority
        wr(1, 1'b0, mk_lo(8'h11, 3'b111, 1'b0, 1'b0, 1'b0));
        wr(3, 1'b0, mk_lo(8'h33, 3'd0, 1'b0, 1'b0, 1'b0));
        wr(5, 1'b0, mk_lo(8'h55, 3'd0, 1'b0, 1'b0, 1'b0));
        acc_q.delete();
        mark = n_acc;
        evt(1, 1'b1);
        for (int k = 0; k < 10 && !leg_req; k++) @(negedge clk);
        tick();
        evt(5, 1'b1);
        evt(3, 1'b1);
        repeat (4) tick();
        @(negedge clk);
        chk("R10 waiting on legacy vector", {63'b0, leg_req}, 64'h1);
        chk("R10 no message while waiting", {63'b0, dlv_valid}, 64'h0);
        tick();
        leg_vector = 8'hA7;
        leg_ack    = 1'b1;
        tick();
        leg_ack    = 1'b0;
        settle();
        chk("R10 three messages", n_acc - mark, 3);
        if (acc_q.size() == 3) begin
            chk("R10 legacy vector used", {56'b0, acc_q[0]}, 64'hA7);
            chk("R7 lower pin first", {56'b0, acc_q[1]}, 64'h33);
            chk("R7 higher pin last", {56'b0, acc_q[2]}, 64'h55);
        end

        // R9 backpressure
        dlv_ready = 1'b0;
        mark = n_acc;
        evt(4, 1'b1);
        repeat (6) tick();
        @(negedge clk);
        chk("R9 message held under backpressure", {63'b0, dlv_valid}, 64'h1);
        chk("R9 nothing accepted yet", n_acc - mark, 0);
        tick();
        dlv_ready = 1'b1;
        settle();
        chk("R9 exactly one delivery after release", n_acc - mark, 1);

        // R11 write re-evaluates a held level pin
        wr(12, 1'b0, mk_lo(8'hC0, 3'd0, 1'b0, 1'b1, 1'b1));
        mark = n_acc;
        evt(12, 1'b1);
        settle();
        chk("R11 masked level pin held", n_acc - mark, 0);
        wr(12, 1'b0, mk_lo(8'hC0, 3'd0, 1'b0, 1'b1, 1'b0));
        settle();
        chk("R11 unmask write delivers", n_acc - mark, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule